// File: doc/BRIEF.md
# Three-Port Register File

This block is a small general-purpose register file: eight 16-bit registers, two read buses that always show the registers named by their own 3-bit selects, and a third port whose role changes with the write enable. When the write enable is high, the register named by the destination select takes the write data on the rising clock edge. When the write enable is low, nothing is stored, and the same destination register is driven out on the bus 0 read output. A datapath can therefore take store data from the register named by the destination field without needing a fourth select.

All reads are combinational. A read that targets the register being written in the same cycle returns the old contents. The new value is seen from the following cycle. A synchronous, active-high reset clears every register to zero. Reset takes priority over a write in the same cycle.

Write data and bus 0 read data are carried on separate signals, so the block has no tristate nets. The bus 0 read output is held at zero for as long as the write enable is high.

Top module: `regfile3p`

## Requirements
- R1: On a rising edge with `rst` high, all eight registers become 0x0000. This is visible on every read bus in the cycles that follow.
- R2: `bus1` always shows the current contents of the register numbered by `sel1` (0 to 7), with no clock involved.
- R3: `bus2` always shows the current contents of the register numbered by `sel2`. When `sel1` equals `sel2`, the two buses carry the same value.
- R4: On a rising edge with `wr_en` high and `rst` low, the register numbered by `sel0` takes `wr_data`. No other register changes.
- R5: On a rising edge with `wr_en` low and `rst` low, no register changes, whatever the value of `wr_data`.
- R6: While `wr_en` is low, `bus0_rd` shows the contents of the register numbered by `sel0`.
- R7: While `wr_en` is high, `bus0_rd` is 0x0000.
- R8: In the cycle of a write, `bus1` and `bus2` show the value the target register held before the edge. The written value appears from the next cycle.
- R9: When `rst` and `wr_en` are both high at an edge, the reset wins and the target register becomes 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset take effect on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wr_en | input | 1 | Write enable for the port named by `sel0` |
| sel0 | input | 3 | Destination select: write target, or bus 0 read source |
| sel1 | input | 3 | Register select for `bus1` |
| sel2 | input | 3 | Register select for `bus2` |
| wr_data | input | 16 | Data stored into register `sel0` when `wr_en` is high |
| bus0_rd | output | 16 | Contents of register `sel0` when `wr_en` is low; zero otherwise |
| bus1 | output | 16 | Contents of register `sel1` |
| bus2 | output | 16 | Contents of register `sel2` |

## Verification
The properties assume that the selects and the write enable are stable and known at each rising edge. The stability properties also assume that `sel1` is held across an edge when they relate `bus1` before and after that edge.

The stimulus changes every input shortly after the falling edge and keeps them constant through the next rising edge. It never drives X onto a select. It begins with reset held high, so the registers are defined before any read is compared.

// File: rtl/rf3p_pkg.sv
package rf3p_pkg;
  localparam int unsigned RF_WIDTH = 16;
  localparam int unsigned RF_DEPTH = 8;
  localparam int unsigned RF_PORTS = 3;
endpackage

// File: rtl/rf3p_store.sv
module rf3p_store #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SELW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SELW-1:0]  waddr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] cells [DEPTH]
);
  // One enable per entry, decoded from the write address.
  logic [DEPTH-1:0] hit;

  always_comb begin
    hit = '0;
    hit[waddr] = we;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        cells[e] <= '0;
      end else if (hit[e]) begin
        cells[e] <= wdata;
      end
    end
  end
endmodule

// File: rtl/rf3p_rdmux.sv
module rf3p_rdmux #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SELW = $clog2(DEPTH)
) (
  input  logic [WIDTH-1:0] cells [DEPTH],
  input  logic [SELW-1:0]  sel,
  input  logic             blank,
  output logic [WIDTH-1:0] dout
);
  // Combinational read; a blanked port drives zero instead of floating.
  always_comb begin
    if (blank) begin
      dout = '0;
    end else begin
      dout = cells[sel];
    end
  end
endmodule

// File: rtl/regfile3p.sv
module regfile3p #(
  parameter int unsigned WIDTH = rf3p_pkg::RF_WIDTH,
  parameter int unsigned DEPTH = rf3p_pkg::RF_DEPTH,
  localparam int unsigned SELW = $clog2(DEPTH),
  localparam int unsigned NPORT = rf3p_pkg::RF_PORTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SELW-1:0]  sel0,
  input  logic [SELW-1:0]  sel1,
  input  logic [SELW-1:0]  sel2,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] bus0_rd,
  output logic [WIDTH-1:0] bus1,
  output logic [WIDTH-1:0] bus2
);
  logic [WIDTH-1:0] cells [DEPTH];
  logic [SELW-1:0]  port_sel   [NPORT];
  logic             port_blank [NPORT];
  logic [WIDTH-1:0] port_out   [NPORT];

  rf3p_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (sel0),
    .wdata (wr_data),
    .cells (cells)
  );

  // Port 0 shares the destination select and reads only while not writing.
  assign port_sel[0]   = sel0;
  assign port_sel[1]   = sel1;
  assign port_sel[2]   = sel2;
  assign port_blank[0] = wr_en;
  assign port_blank[1] = 1'b0;
  assign port_blank[2] = 1'b0;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    rf3p_rdmux #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mux (
      .cells (cells),
      .sel   (port_sel[p]),
      .blank (port_blank[p]),
      .dout  (port_out[p])
    );
  end

  assign bus0_rd = port_out[0];
  assign bus1    = port_out[1];
  assign bus2    = port_out[2];
endmodule

// File: rtl/regfile3p_chk.sv
module regfile3p_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned SELW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [SELW-1:0]  sel0,
  input logic [SELW-1:0]  sel1,
  input logic [SELW-1:0]  sel2,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] bus0_rd,
  input logic [WIDTH-1:0] bus1,
  input logic [WIDTH-1:0] bus2
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bus1 == '0 && bus2 == '0));

  // R3
  same_sel_match_chk: assert property (@(posedge clk) disable iff (rst)
    (sel1 == sel2) |-> (bus1 == bus2));

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (sel1 != $past(sel0) || bus1 == $past(wr_data)));

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!$stable(sel1) || $stable(bus1)));

  // R6
  bus0_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && sel0 == sel1) |-> (bus0_rd == bus1));

  // R7
  bus0_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (bus0_rd == '0));
endmodule

bind regfile3p regfile3p_chk #(.WIDTH(WIDTH), .SELW(SELW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .sel0    (sel0),
  .sel1    (sel1),
  .sel2    (sel2),
  .wr_data (wr_data),
  .bus0_rd (bus0_rd),
  .bus1    (bus1),
  .bus2    (bus2)
);

// File: tb/regfile3p_bench.sv
module regfile3p_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  sel0 = '0, sel1 = '0, sel2 = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] bus0_rd, bus1, bus2;

  typedef struct {
    string       tag;
    logic [15:0] e0, e1, e2;
  } exp_t;

  exp_t        q[$];
  logic [15:0] model [8];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  regfile3p u_regfile3p (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel0(sel0), .sel1(sel1),
    .sel2(sel2), .wr_data(wr_data), .bus0_rd(bus0_rd), .bus1(bus1), .bus2(bus2)
  );

  // Driver: applies one cycle of stimulus, queues the expected outputs,
  // then advances the reference model across the coming rising edge.
  task automatic step(input logic r, input logic we, input logic [2:0] s0,
                      input logic [2:0] s1, input logic [2:0] s2,
                      input logic [15:0] d, input string tag, input bit chk);
    exp_t x;
    @(negedge clk);
    #1;
    rst = r; wr_en = we; sel0 = s0; sel1 = s1; sel2 = s2; wr_data = d;
    if (chk) begin
      x.tag = tag;
      x.e0  = we ? 16'h0000 : model[s0];
      x.e1  = model[s1];
      x.e2  = model[s2];
      q.push_back(x);
    end
    if (r) begin
      for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    end else if (we) begin
      model[s0] = d;
    end
  endtask

  // Monitor: compares queued expectations mid-cycle, away from the edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        checks++;
        if (bus0_rd !== x.e0 || bus1 !== x.e1 || bus2 !== x.e2) begin
          errors++;
          $display("FAIL %s: bus0=%h bus1=%h bus2=%h expected %h %h %h",
                   x.tag, bus0_rd, bus1, bus2, x.e0, x.e1, x.e2);
        end
      end
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 16'hxxxx;
    step(1, 0, 0, 0, 0, 16'h0, "R1", 0);
    step(1, 0, 0, 0, 0, 16'h0, "R1", 0);
    // R1: everything reads zero after reset
    for (int i = 0; i < 8; i++) step(0, 0, 3'(i), 3'(i), 3'(7 - i), 16'h0, "R1", 1);
    // R4 / R7 / R8: write every entry; buses show the old value this cycle
    for (int i = 0; i < 8; i++)
      step(0, 1, 3'(i), 3'(i), 3'(i), 16'h1111 * 16'(i + 1) ^ 16'hA05A, "R8", 1);
    // R2 / R3 / R6: read combinations in several orders
    for (int i = 0; i < 8; i++) step(0, 0, 3'(i), 3'(7 - i), 3'((i * 3) % 8), 16'h0, "R2", 1);
    for (int i = 0; i < 8; i++) step(0, 0, 3'((i + 5) % 8), 3'(i), 3'(i), 16'h0, "R3", 1);
    // R5: idle cycles with junk write data must not disturb anything
    for (int i = 0; i < 8; i++) step(0, 0, 3'(i), 3'(i), 3'(i), 16'hDEAD, "R5", 1);
    // R4: one rewrite, neighbours checked the next cycle
    step(0, 1, 3'd3, 3'd2, 3'd4, 16'hBEEF, "R7", 1);
    step(0, 0, 3'd3, 3'd2, 3'd4, 16'h0, "R4", 1);
    step(0, 0, 3'd5, 3'd3, 3'd3, 16'h0, "R6", 1);
    // R9: reset with a write in the same cycle clears the target
    step(1, 1, 3'd6, 3'd6, 3'd6, 16'h7777, "R9", 0);
    step(0, 0, 3'd6, 3'd6, 3'd0, 16'h0, "R9", 1);
    step(0, 0, 3'd3, 3'd1, 3'd7, 16'h0, "R1", 1);
    @(negedge clk);
    @(negedge clk);
    #5;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule